// File: doc/BRIEF.md
# Dual-Source Priority Output Queue

This block is the byte output stage of a keyboard and pointing-device host controller. Bytes from the keyboard side and from the auxiliary (mouse) side each go into their own circular queue. The host drains both queues through one read port. A read strobe takes the next byte from the keyboard queue. It takes a byte from the auxiliary queue only when the keyboard queue is empty. If both queues are empty, the read returns the last keyboard byte again.

The block publishes a two-bit status word that tells the host which source has a byte waiting. It also drives one interrupt line per source, and each line is gated by its own enable pin. Each producer pushes through a valid/ready pair. Ready is high while its queue has room. A push offered while ready is low is dropped, and the block never stalls the producer. The producer may hold the byte and retry, or let it go. The host side is a plain strobe with a registered data output. It has no back-pressure: every strobe is honoured.

Top module: `kbq_dual_outq`

## Requirements
- R1: On a host read, the keyboard queue is popped when it holds a byte. The auxiliary queue is popped only when the keyboard queue is empty, and a keyboard pop leaves the auxiliary count unchanged.
- R2: Each queue returns its bytes in push order and holds up to DEPTH bytes. Its read and write indices wrap modulo DEPTH.
- R3: `kb_push_ready` and `aux_push_ready` are high exactly when their queue holds fewer than DEPTH bytes. A push offered while ready is low is discarded, and the count of that queue is unchanged.
- R4: A host read with both queues empty presents the most recently read keyboard byte (0x00 if no keyboard byte has been read since reset). It pops nothing.
- R5: `host_rd_data` changes only on the clock edge that samples `host_rd`, and it holds its value until the next read.
- R6: `status_obf` bit 0 is 1 when the keyboard queue holds a byte. Bit 1 is 1 when the keyboard queue is empty and the auxiliary queue holds a byte. Both bits come from the queue counts of the previous cycle. On the edge that samples `host_rd`, both bits are forced to 0.
- R7: `irq_kb` equals `status_obf[0]` AND `kb_irq_en`, and `irq_aux` equals `status_obf[1]` AND `aux_irq_en`. A disabled source still accepts pushes.
- R8: A push and a pop on the same non-empty, non-full queue in the same cycle are both carried out, and the count is unchanged.
- R9: Reset empties both queues, sets the read data and the held keyboard byte to 0x00, clears both status bits and deasserts both interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_push_valid | input | 1 | Keyboard byte offered |
| kb_push_data | input | W | Keyboard byte |
| kb_push_ready | output | 1 | Keyboard queue has room |
| aux_push_valid | input | 1 | Auxiliary byte offered |
| aux_push_data | input | W | Auxiliary byte |
| aux_push_ready | output | 1 | Auxiliary queue has room |
| host_rd | input | 1 | Host read strobe, one byte per cycle high |
| host_rd_data | output | W | Byte returned by the last read |
| kb_irq_en | input | 1 | Keyboard interrupt enable |
| aux_irq_en | input | 1 | Auxiliary interrupt enable |
| status_obf | output | 2 | Bit 0 keyboard byte waiting, bit 1 auxiliary byte waiting |
| irq_kb | output | 1 | Keyboard interrupt request |
| irq_aux | output | 1 | Auxiliary interrupt request |

## Verification
A push changes its queue count, and therefore the ready pin, at the edge that accepts it. The status bits follow one edge later. A read presents its byte at the edge that samples the strobe, and in that same edge it clears the status bits and the interrupt lines. The recomputed flags appear one edge after that. The bench drives inputs on the falling edge and advances a behavioural model of the next rising edge. On the following falling edge it compares every output against that model, so each expected value is taken in the cycle the design produces it.

// File: rtl/kbq_pkg.sv
package kbq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_KB   = 2'd1,
    SRC_AUX  = 2'd2
  } src_e;
endpackage

// File: rtl/kbq_ring.sv
module kbq_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [W-1:0]  push_data,
  input  logic          pop_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push_en && !full;
  assign do_pop  = pop_en && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_en && !pop_en |=> count == $past(count));

  // R8
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && pop_en && !full && !empty |=> count == $past(count));

  // R2
  single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && !pop_en && !full |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/kbq_drain_sel.sv
module kbq_drain_sel
  import kbq_pkg::*;
(
  input  logic rd_stb,
  input  logic kb_empty,
  input  logic aux_empty,
  output logic pop_kb,
  output logic pop_aux,
  output src_e src
);
  always_comb begin
    pop_kb  = 1'b0;
    pop_aux = 1'b0;
    src     = SRC_NONE;
    if (rd_stb) begin
      if (!kb_empty) begin
        pop_kb = 1'b1;
        src    = SRC_KB;
      end else if (!aux_empty) begin
        pop_aux = 1'b1;
        src     = SRC_AUX;
      end
    end
  end
endmodule

// File: rtl/kbq_flags.sv
module kbq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  logic       kb_pending,
  input  logic       aux_pending,
  input  logic       kb_irq_en,
  input  logic       aux_irq_en,
  output logic [1:0] status,
  output logic       irq_kb,
  output logic       irq_aux
);
  always_ff @(posedge clk) begin
    if (!rst_n)      status <= 2'b00;
    else if (rd_stb) status <= 2'b00;
    else             status <= {aux_pending && !kb_pending, kb_pending};
  end

  assign irq_kb  = status[0] && kb_irq_en;
  assign irq_aux = status[1] && aux_irq_en;

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> status == 2'b00);

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !irq_kb && !irq_aux);

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status));
endmodule

// File: rtl/kbq_dual_outq.sv
module kbq_dual_outq
  import kbq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kb_push_valid,
  input  logic [W-1:0] kb_push_data,
  output logic         kb_push_ready,
  input  logic         aux_push_valid,
  input  logic [W-1:0] aux_push_data,
  output logic         aux_push_ready,
  input  logic         host_rd,
  output logic [W-1:0] host_rd_data,
  input  logic         kb_irq_en,
  input  logic         aux_irq_en,
  output logic [1:0]   status_obf,
  output logic         irq_kb,
  output logic         irq_aux
);
  logic [W-1:0]  kb_head, aux_head, last_kb;
  logic [CW-1:0] kb_cnt, aux_cnt;
  logic          kb_full, kb_empty, aux_full, aux_empty;
  logic          pop_kb, pop_aux;
  src_e          src;

  kbq_ring #(.DEPTH(DEPTH), .W(W)) kb_q_i (
    .clk(clk), .rst_n(rst_n),
    .push_en(kb_push_valid), .push_data(kb_push_data),
    .pop_en(pop_kb), .head(kb_head), .count(kb_cnt),
    .full(kb_full), .empty(kb_empty)
  );

  kbq_ring #(.DEPTH(DEPTH), .W(W)) aux_q_i (
    .clk(clk), .rst_n(rst_n),
    .push_en(aux_push_valid), .push_data(aux_push_data),
    .pop_en(pop_aux), .head(aux_head), .count(aux_cnt),
    .full(aux_full), .empty(aux_empty)
  );

  kbq_drain_sel sel_i (
    .rd_stb(host_rd), .kb_empty(kb_empty), .aux_empty(aux_empty),
    .pop_kb(pop_kb), .pop_aux(pop_aux), .src(src)
  );

  kbq_flags flags_i (
    .clk(clk), .rst_n(rst_n), .rd_stb(host_rd),
    .kb_pending(!kb_empty), .aux_pending(!aux_empty),
    .kb_irq_en(kb_irq_en), .aux_irq_en(aux_irq_en),
    .status(status_obf), .irq_kb(irq_kb), .irq_aux(irq_aux)
  );

  assign kb_push_ready  = !kb_full;
  assign aux_push_ready = !aux_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rd_data <= '0;
      last_kb      <= '0;
    end else if (host_rd) begin
      case (src)
        SRC_KB: begin
          host_rd_data <= kb_head;
          last_kb      <= kb_head;
        end
        SRC_AUX: host_rd_data <= aux_head;
        default: host_rd_data <= last_kb;
      endcase
    end
  end

  // R1
  kb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && kb_cnt != '0 |=> aux_cnt >= $past(aux_cnt));

  // R4
  empty_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && kb_cnt == '0 && aux_cnt == '0 |=> host_rd_data == $past(last_kb));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rd_data));
endmodule

// File: tb/kbq_dual_outq_tb_top.sv
module kbq_dual_outq_tb_top;
  localparam int D = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         kb_push_valid = 1'b0, aux_push_valid = 1'b0, host_rd = 1'b0;
  logic [W-1:0] kb_push_data = '0, aux_push_data = '0;
  logic         kb_irq_en = 1'b1, aux_irq_en = 1'b1;
  logic         kb_push_ready, aux_push_ready, irq_kb, irq_aux;
  logic [W-1:0] host_rd_data;
  logic [1:0]   status_obf;

  int    total = 0, bad = 0;
  string tag = "R9";

  logic [W-1:0] kq[$], aq[$];
  logic [W-1:0] m_data = '0, m_last = '0;
  logic [1:0]   m_st = 2'b00;

  always #5 clk = ~clk;

  kbq_dual_outq #(.DEPTH(D), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .kb_push_valid(kb_push_valid), .kb_push_data(kb_push_data), .kb_push_ready(kb_push_ready),
    .aux_push_valid(aux_push_valid), .aux_push_data(aux_push_data), .aux_push_ready(aux_push_ready),
    .host_rd(host_rd), .host_rd_data(host_rd_data),
    .kb_irq_en(kb_irq_en), .aux_irq_en(aux_irq_en),
    .status_obf(status_obf), .irq_kb(irq_kb), .irq_aux(irq_aux)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rd_data", 32'(host_rd_data), 32'(m_data));
    chk("status", 32'(status_obf), 32'(m_st));
    chk("irq_kb", 32'(irq_kb), 32'(m_st[0] & kb_irq_en));
    chk("irq_aux", 32'(irq_aux), 32'(m_st[1] & aux_irq_en));
    chk("kb_ready", 32'(kb_push_ready), 32'(kq.size() < D));
    chk("aux_ready", 32'(aux_push_ready), 32'(aq.size() < D));
  endtask

  // Drive at the falling edge, model the next rising edge, check at the next falling edge.
  task automatic step(input logic kv, input logic [W-1:0] kd,
                      input logic av, input logic [W-1:0] ad, input logic rd);
    logic [1:0] nst;
    logic       kacc, aacc;
    kb_push_valid = kv; kb_push_data = kd;
    aux_push_valid = av; aux_push_data = ad;
    host_rd = rd;
    nst  = rd ? 2'b00 : {kq.size() == 0 && aq.size() != 0, kq.size() != 0};
    kacc = kv && (kq.size() < D);
    aacc = av && (aq.size() < D);
    if (rd) begin
      if (kq.size() != 0) begin
        m_data = kq.pop_front();
        m_last = m_data;
      end else if (aq.size() != 0) begin
        m_data = aq.pop_front();
      end else begin
        m_data = m_last;
      end
    end
    if (kacc) kq.push_back(kd);
    if (aacc) aq.push_back(ad);
    m_st = nst;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    tag = "R9";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R4: read while empty returns 0x00 after reset
    tag = "R4";
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);

    // R1 / R2: keyboard bytes drain before auxiliary bytes, in order
    tag = "R1";
    step(1, 8'h11, 1, 8'hA1, 0);
    step(1, 8'h12, 1, 8'hA2, 0);
    step(1, 8'h13, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    tag = "R2";
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1);
    // R4: repeat of last keyboard byte 0x13
    tag = "R4";
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);

    // R3: overfill both queues
    tag = "R3";
    for (int i = 0; i < D + 3; i++) step(1, 8'h20 + 8'(i), 1, 8'h40 + 8'(i), 0);
    // R8: push and pop together at full, then below full
    tag = "R8";
    step(1, 8'h77, 0, 0, 1);
    step(1, 8'h78, 0, 0, 1);
    step(1, 8'h79, 0, 0, 1);
    // R5: data holds without reads
    tag = "R5";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);

    // R7: interrupt gating, disabled source still queues
    tag = "R7";
    kb_irq_en = 1'b0;
    for (int i = 0; i < D + 1; i++) step(0, 0, 0, 0, 1);
    step(1, 8'h55, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    kb_irq_en = 1'b1; aux_irq_en = 1'b0;
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < D + 2; i++) step(0, 0, 0, 0, 1);
    aux_irq_en = 1'b1;

    // R6: status and interrupts under mixed random traffic
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (i % 500 == 250) begin
        kb_irq_en = ~kb_irq_en;
        aux_irq_en = ($urandom_range(0, 1) == 1);
      end
      step(r < 40, 8'($urandom), (r % 3) == 0, 8'($urandom), (r % 4) == 1 || r > 85);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule